// File: doc/BRIEF.md
# Performance Counter Unit

This block gives a CPU core a small set of performance counters. One 32-bit counter tracks clock cycles, either every clock or once every 64 clocks. Two more 32-bit counters each watch one of 64 event inputs, chosen by a 6-bit selector, and add one in each cycle where that input is high. A single control word holds the global enable, the scaling choice, the interrupt enables, the sticky overflow flags, the two selectors and two self-clearing clear bits.

Software reaches all four registers through a plain system-register port with an address, a write strobe, write data and combinational read data. A write to a counter address loads that counter directly, so software can start it near the top to get an early overflow. When a counter wraps, it sets its own flag. The interrupt output is high while any flag is set together with its enable, which lets software keep the upper bits of a wider count.

Register addresses on `reg_addr`: 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all three counters and every control field read as zero, and `irq` is low.
- R2: With enable (control bit 0) set and scale (bit 3) clear, the cycle counter adds one on every clock.
- R3: With enable and scale both set, the cycle counter adds one once per 64 clocks. The 64-clock phase counts only while both bits are set, and it restarts at zero on reset or on a write of 1 to control bit 2.
- R4: With enable set, event counter 0 adds one in each cycle where `events[sel0]` is high, and event counter 1 does the same for `events[sel1]`. sel0 is control bits 17:12 and sel1 is control bits 23:18.
- R5: With enable clear, no counter changes except through a direct write or a clear bit.
- R6: A counter at 0xFFFF_FFFF that increments goes to zero and sets its overflow flag. The flags are control bits 8 (cycle), 9 (event 0) and 10 (event 1).
- R7: `irq` is the OR, over the three counters, of each flag ANDed with its enable. The enables are control bits 4 (cycle), 5 (event 0) and 6 (event 1).
- R8: A flag stays set until a control write puts a 1 in its bit. A 0 in that bit leaves it unchanged.
- R9: Writing 1 to control bit 2 clears the cycle counter. Writing 1 to control bit 1 clears both event counters. Both bits always read back as 0.
- R10: A write to a counter address loads the written value, and this value wins over an increment in the same cycle.
- R11: Control bits 7, 11 and 31:24 read back as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| events | input | 64 | Event inputs, one bit per source |
| irq | output | 1 | Overflow interrupt request |

## Verification
Reaching an overflow by counting alone would take four billion cycles, so the hardest case to reach is a wrap, most of all a wrap that lands in the same cycle as a flag-clearing control write or a preset. The stimulus reaches wraps by presetting counters a few steps below 0xFFFF_FFFF, both in directed cases and within the random mix. Random control writes then set and clear flags, enables and clear bits around those wraps. The scaled cycle mode is driven long enough to cross two full 64-clock periods after a phase reset.

// File: rtl/perf_mon_pkg.sv
// Package perf_mon_pkg
// Shared constants for the performance counter unit: the register address
// map and the bit positions in the control word.
package perf_mon_pkg;
    localparam int ADDR_W  = 2;
    localparam int N_CNT   = 3;
    localparam int SEL_W   = 6;
    localparam int N_EVENTS = 1 << SEL_W;

    // Control word bit positions
    localparam int BIT_EN     = 0;
    localparam int BIT_CLR_EV = 1;
    localparam int BIT_CLR_CY = 2;
    localparam int BIT_SCALE  = 3;
    localparam int IE_LO      = 4;
    localparam int FLAG_LO    = 8;
    localparam int SEL0_LO    = 12;
    localparam int SEL1_LO    = 18;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_CYC  = 2'd1,
        ADR_EV0  = 2'd2,
        ADR_EV1  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/perf_counter.sv
// Module perf_counter
// One wrapping up-counter. Priority is load, then clear, then increment.
// The overflow pulse is high only when an increment that is actually
// applied takes the counter from all ones to zero.
module perf_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    // Counter register with load > clear > increment priority
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clear) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // Wrap detection for an increment that takes effect
    assign ovf = inc && !load && !clear && (cnt == '1);
endmodule

// File: rtl/perf_prescaler.sv
// Module perf_prescaler
// Free-running divider that gives one tick every 2**LOG2 enabled clocks.
// It holds while run is low and restarts at zero on clear.
module perf_prescaler #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    logic [LOG2-1:0] phase;

    // Phase counter that advances only while run is high
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= '0;
        else if (clear) phase <= '0;
        else if (run)   phase <= phase + 1'b1;
    end

    // Tick on the last phase of each period
    assign tick = run && (phase == '1);
endmodule

// File: rtl/perf_ctrl_reg.sv
// Module perf_ctrl_reg
// Holds the control word. The clear bits are decoded straight from the
// write and never stored. Overflow flags are sticky: a write of 1 clears a
// flag, but an overflow in the same cycle keeps it set.
module perf_ctrl_reg
    import perf_mon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_CNT-1:0]  cnt_ovf,
    output logic              ctl_en,
    output logic              ctl_scale,
    output logic [N_CNT-1:0]  ctl_ie,
    output logic [N_CNT-1:0]  ctl_flag,
    output logic [SEL_W-1:0]  ctl_sel0,
    output logic [SEL_W-1:0]  ctl_sel1,
    output logic              clr_cyc,
    output logic              clr_ev,
    output logic [DATA_W-1:0] rdata
);
    logic [N_CNT-1:0] flag_clr;

    assign clr_cyc  = wr && wdata[BIT_CLR_CY];
    assign clr_ev   = wr && wdata[BIT_CLR_EV];
    assign flag_clr = wr ? wdata[FLAG_LO +: N_CNT] : '0;

    // Configuration fields loaded on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_scale <= 1'b0;
            ctl_ie    <= '0;
            ctl_sel0  <= '0;
            ctl_sel1  <= '0;
        end else if (wr) begin
            ctl_en    <= wdata[BIT_EN];
            ctl_scale <= wdata[BIT_SCALE];
            ctl_ie    <= wdata[IE_LO +: N_CNT];
            ctl_sel0  <= wdata[SEL0_LO +: SEL_W];
            ctl_sel1  <= wdata[SEL1_LO +: SEL_W];
        end
    end

    // Sticky flags, where a new overflow wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_flag <= '0;
        else        ctl_flag <= (ctl_flag & ~flag_clr) | cnt_ovf;
    end

    // Readback image, with clear bits and reserved bits at zero
    always_comb begin
        rdata                      = '0;
        rdata[BIT_EN]              = ctl_en;
        rdata[BIT_SCALE]           = ctl_scale;
        rdata[IE_LO +: N_CNT]      = ctl_ie;
        rdata[FLAG_LO +: N_CNT]    = ctl_flag;
        rdata[SEL0_LO +: SEL_W]    = ctl_sel0;
        rdata[SEL1_LO +: SEL_W]    = ctl_sel1;
    end
endmodule

// File: rtl/perf_mon_unit.sv
// Module perf_mon_unit
// Performance counter unit: a cycle counter and two event counters behind
// a four-entry register port, with a combined overflow interrupt.
// Assumes the event inputs are synchronous to clk and DATA_W >= 24, so
// that the control fields fit.
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int PRESCALE_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [N_EVENTS-1:0] events,
    output logic                irq
);
    logic              ctl_en, ctl_scale, clr_cyc, clr_ev, pre_tick;
    logic [N_CNT-1:0]  ctl_ie, ctl_flag, cnt_ovf, cnt_inc, cnt_load, cnt_clr;
    logic [SEL_W-1:0]  ctl_sel0, ctl_sel1;
    logic [DATA_W-1:0] ctrl_rdata;
    logic [DATA_W-1:0] cnt [N_CNT];

    perf_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_we && (reg_addr == ADR_CTRL)), .wdata(reg_wdata),
        .cnt_ovf(cnt_ovf),
        .ctl_en(ctl_en), .ctl_scale(ctl_scale), .ctl_ie(ctl_ie),
        .ctl_flag(ctl_flag), .ctl_sel0(ctl_sel0), .ctl_sel1(ctl_sel1),
        .clr_cyc(clr_cyc), .clr_ev(clr_ev), .rdata(ctrl_rdata)
    );

    perf_prescaler #(.LOG2(PRESCALE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(clr_cyc),
        .run(ctl_en && ctl_scale), .tick(pre_tick)
    );

    // Increment sources: the clock, either scaled or direct, and two selected events
    always_comb begin
        cnt_inc[0] = ctl_en && (ctl_scale ? pre_tick : 1'b1);
        cnt_inc[1] = ctl_en && events[ctl_sel0];
        cnt_inc[2] = ctl_en && events[ctl_sel1];
        cnt_clr    = {clr_ev, clr_ev, clr_cyc};
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        assign cnt_load[g] = reg_we && (reg_addr == ADDR_W'(g + 1));
        perf_counter #(.W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .load(cnt_load[g]), .load_val(reg_wdata),
            .clear(cnt_clr[g]), .inc(cnt_inc[g]),
            .cnt(cnt[g]), .ovf(cnt_ovf[g])
        );
    end

    // Register read multiplexer
    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = ctrl_rdata;
            ADR_CYC:  reg_rdata = cnt[0];
            ADR_EV0:  reg_rdata = cnt[1];
            default:  reg_rdata = cnt[2];
        endcase
    end

    assign irq = |(ctl_flag & ctl_ie);
endmodule

// File: rtl/perf_mon_checker.sv
// Module perf_mon_checker
// Property checks for perf_mon_unit, attached by bind. It watches the
// ports and a few internal nets; it drives nothing.
module perf_mon_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] cyc_cnt,
    input logic              ctl_en,
    input logic              ctl_scale,
    input logic [2:0]        ctl_flag,
    input logic [2:0]        cnt_ovf
);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == 2'd0);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !reg_we) |=> $stable(cyc_cnt));

    a_r6_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == '1 && ctl_en && !ctl_scale && !reg_we) |=> (cyc_cnt == '0 && ctl_flag[0]));

    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|cnt_ovf) || ctrl_wr));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_flag[0] && !(ctrl_wr && reg_wdata[8])) |=> ctl_flag[0]);

    a_r9_cycle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[2]) |=> (cyc_cnt == '0));

    a_r10_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1) |=> (cyc_cnt == $past(reg_wdata)));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[2:1] == 2'b00 && !reg_rdata[7] && !reg_rdata[11]
                                && reg_rdata[31:24] == 8'h00));
endmodule

bind perf_mon_unit perf_mon_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cyc_cnt(cnt[0]), .ctl_en(ctl_en), .ctl_scale(ctl_scale),
    .ctl_flag(ctl_flag), .cnt_ovf(cnt_ovf)
);

// File: tb/perf_mon_unit_test.sv
// Testbench for perf_mon_unit: directed corner cases, then a seeded random
// mix. Each cycle is compared with a bench model built from the requirements.
module perf_mon_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] events;
    logic        irq;

    int tests = 0;
    int fails = 0;

    // Bench model state
    logic [31:0] m_cnt [3];
    logic        m_en, m_scale;
    logic [2:0]  m_ie, m_flag;
    logic [5:0]  m_sel0, m_sel1, m_pre;

    always #5 clk = ~clk;

    perf_mon_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .irq(irq)
    );

    function automatic logic [31:0] m_read(logic [1:0] a);
        if (a == 2'd0)
            return {8'h00, m_sel1, m_sel0, 1'b0, m_flag, 1'b0, m_ie, m_scale, 2'b00, m_en};
        return m_cnt[a - 2'd1];
    endfunction

    function automatic logic [31:0] ctl(logic en, logic sc, logic [2:0] ie, logic [2:0] fclr,
                                        logic [5:0] s0, logic [5:0] s1, logic clr_ev, logic clr_cy);
        return {8'h00, s1, s0, 1'b0, fclr, 1'b0, ie, sc, clr_cy, clr_ev, en};
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Advance the model by one clock with the given inputs
    task automatic m_step(logic we, logic [1:0] a, logic [31:0] wd, logic [63:0] ev);
        logic [2:0] inc, ovf, ld, clr;
        logic cw;
        cw     = we && a == 2'd0;
        inc[0] = m_en && (!m_scale || m_pre == 6'd63);
        inc[1] = m_en && ev[m_sel0];
        inc[2] = m_en && ev[m_sel1];
        clr    = {cw && wd[1], cw && wd[1], cw && wd[2]};
        for (int i = 0; i < 3; i++) begin
            ld[i]  = we && a == 2'(i + 1);
            ovf[i] = inc[i] && !ld[i] && !clr[i] && m_cnt[i] == 32'hFFFF_FFFF;
            if (ld[i])       m_cnt[i] = wd;
            else if (clr[i]) m_cnt[i] = 32'h0;
            else if (inc[i]) m_cnt[i] = m_cnt[i] + 32'd1;
        end
        if (clr[0])                m_pre = 6'd0;
        else if (m_en && m_scale)  m_pre = m_pre + 6'd1;
        m_flag = (m_flag & ~(cw ? wd[10:8] : 3'b000)) | ovf;
        if (cw) begin
            m_en = wd[0]; m_scale = wd[3]; m_ie = wd[6:4];
            m_sel0 = wd[17:12]; m_sel1 = wd[23:18];
        end
    endtask

    // One clock: drive, check reads and irq before the edge, then update the model
    task automatic step(logic we, logic [1:0] a, logic [31:0] wd, logic [63:0] ev, string tag);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd; events = ev;
        #1;
        if (!we) check(reg_rdata, m_read(a), tag);
        check({31'd0, irq}, {31'd0, |(m_flag & m_ie)}, "R7 irq");
        @(posedge clk);
        m_step(we, a, wd, ev);
    endtask

    task automatic rd(logic [1:0] a, string tag);
        step(1'b0, a, 32'h0, events, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] wd, string tag);
        step(1'b1, a, wd, events, tag);
    endtask

    task automatic idle(int n, logic [63:0] ev);
        for (int i = 0; i < n; i++) step(1'b0, 2'd1, 32'h0, ev, "R2 idle");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; events = '0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 32'h0;
        m_en = 0; m_scale = 0; m_ie = 0; m_flag = 0; m_sel0 = 0; m_sel1 = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset");

        // R5: disabled counters ignore events
        for (int i = 0; i < 5; i++) step(1'b0, 2'd2, 32'h0, '1, "R5 disabled");
        rd(2'd1, "R5 cycle"); rd(2'd3, "R5 ev1");

        // R2 / R4: enable with selectors 5 and 63
        wr(2'd0, ctl(1, 0, 3'b000, 3'b000, 6'd5, 6'd63, 0, 0), "R4 cfg");
        for (int i = 0; i < 20; i++) step(1'b0, 2'd2, 32'h0, {$urandom, $urandom}, "R4 ev0");
        rd(2'd1, "R2 cycle"); rd(2'd2, "R4 ev0"); rd(2'd3, "R4 ev1");

        // R10: preset beats increment
        wr(2'd1, 32'h1234_5678, "R10 preset");
        rd(2'd1, "R10 preset value");

        // R6 / R7: cycle wrap with interrupt enabled
        wr(2'd0, ctl(1, 0, 3'b001, 3'b000, 6'd5, 6'd63, 0, 0), "R7 cfg");
        wr(2'd1, 32'hFFFF_FFFE, "R6 preset");
        idle(3, '0);
        rd(2'd0, "R6 flag"); rd(2'd1, "R6 wrapped");

        // R6: event counter wrap
        wr(2'd3, 32'hFFFF_FFFF, "R6 ev1 preset");
        step(1'b0, 2'd3, 32'h0, 64'h8000_0000_0000_0000, "R6 ev1 at top");
        rd(2'd3, "R6 ev1 wrapped"); rd(2'd0, "R6 ev1 flag");

        // R8: a 0 in a flag bit keeps it; a 1 clears it
        wr(2'd0, ctl(1, 0, 3'b111, 3'b000, 6'd5, 6'd63, 0, 0), "R8 keep");
        rd(2'd0, "R8 kept");
        wr(2'd0, ctl(1, 0, 3'b111, 3'b101, 6'd5, 6'd63, 0, 0), "R8 clear");
        rd(2'd0, "R8 cleared");

        // R9: clear bits
        wr(2'd0, ctl(1, 0, 3'b000, 3'b111, 6'd5, 6'd63, 0, 1), "R9 clear cyc");
        rd(2'd1, "R9 cyc zero");
        wr(2'd0, ctl(0, 0, 3'b000, 3'b000, 6'd5, 6'd63, 1, 0), "R9 clear ev");
        rd(2'd2, "R9 ev0 zero"); rd(2'd3, "R9 ev1 zero"); rd(2'd0, "R9 bits read 0");

        // R3: scaled cycle counting over two full periods
        wr(2'd0, ctl(1, 1, 3'b000, 3'b000, 6'd0, 6'd0, 0, 1), "R3 cfg");
        idle(62, '0);
        rd(2'd1, "R3 before tick");
        idle(70, '0);
        rd(2'd1, "R3 after two ticks");

        // R11: reserved bits read back as 0
        wr(2'd0, 32'hFFFF_FFFF, "R11 all ones");
        rd(2'd0, "R11 readback");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] wd;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                wd = $urandom;
                wd[0] = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 3) != 0) wd[2:1] = 2'b00;
                step(1'b1, 2'd0, wd, {$urandom, $urandom}, "R8 rand ctrl");
            end else if (op == 1) begin
                step(1'b1, 2'($urandom_range(1, 3)), 32'hFFFF_FFFF - $urandom_range(0, 20),
                     {$urandom, $urandom}, "R10 rand preset");
            end else begin
                step(1'b0, 2'($urandom_range(0, 3)), 32'h0, {$urandom, $urandom}, "R6 rand read");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule